// File: doc/BRIEF.md
# Bit-Test Branch Execution Unit

This block is the execute stage for the conditional-branch and processor-control group of a small 8-bit controller. Each issued operation arrives already decoded. It carries an operation code, the byte length of the instruction, a signed 8-bit displacement, the current program counter, and the operand byte under test with a bit index. One clock later the block presents the next program counter, a taken flag and, where the operation modifies its operand, a write-back byte with an enable.

The branch forms cover three cases: branch when a chosen bit is one, branch when it is zero, and an atomic test that clears the bit when it branches. A decrement loop primitive lowers an 8-bit counter and branches while the result is nonzero. The branch base is always the address of the following instruction, so the issuing stage supplies the length (2, 3 or 4 bytes). The control group holds the interrupt-enable flag and the 2-bit register-bank selection. It also raises one-cycle halt and stop requests toward an external power controller. Operand fetch, wait states and clock gating are handled elsewhere.

Top module: `bitbr_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero at that edge: `pc_next_o`, `ie_o`, `bank_o`, `taken_o`, `wb_en_o`, `wb_data_o`, `halt_req_o`, `stop_req_o` and `done_o`.
- R2: An operation issued with `valid_i` high shows its results after the next rising edge, and `done_o` is high in that cycle. In a cycle that follows an edge with `valid_i` low, `done_o`, `taken_o`, `wb_en_o`, `halt_req_o` and `stop_req_o` are low and `pc_next_o` holds its value.
- R3: Op code 1 (branch-if-one) is taken when `opnd_i[bit_idx_i]` is 1. A taken branch gives `pc_next_o` = `pc_i` + `len_i` + the sign-extended `disp_i`, modulo 65536. A not-taken branch gives `pc_i` + `len_i`, modulo 65536. Write-back stays off.
- R4: Op code 2 (branch-if-zero) is taken when `opnd_i[bit_idx_i]` is 0, using the same target arithmetic as R3. Write-back stays off.
- R5: Op code 3 (test-and-clear) is taken when the selected bit is 1. In that case `wb_en_o` is 1 and `wb_data_o` equals `opnd_i` with only that bit cleared. When the bit is 0, the branch is not taken and `wb_en_o` is 0.
- R6: Op code 4 (decrement loop) always sets `wb_en_o` with `wb_data_o` = `opnd_i` − 1 modulo 256. It is taken exactly when that result is nonzero, so an input of 0 yields 0xFF and a taken branch.
- R7: Op code 5 (bank select) loads `bank_i` into `bank_o`. No other operation changes `bank_o`.
- R8: Op code 6 sets `ie_o` to 1 and op code 7 clears it. No other operation changes `ie_o`.
- R9: Op code 8 (halt) pulses `halt_req_o` and op code 9 (stop) pulses `stop_req_o`, each high for exactly one cycle and never both at once. `pc_next_o` advances by `len_i`.
- R10: Op code 0 (no operation) and the unused codes 10 to 15 take no branch, write nothing back, and leave `ie_o` and `bank_o` unchanged. `pc_next_o` advances by `len_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| len_i | input | 3 | Instruction length in bytes |
| disp_i | input | 8 | Signed branch displacement |
| pc_i | input | 16 | Address of the current instruction |
| opnd_i | input | 8 | Tested operand byte or loop counter |
| bit_idx_i | input | 3 | Index of the tested bit |
| bank_i | input | 2 | Bank number for bank select |
| pc_next_o | output | 16 | Next program counter |
| taken_o | output | 1 | Branch taken |
| wb_en_o | output | 1 | Write-back byte is valid |
| wb_data_o | output | 8 | Cleared-bit or decremented byte |
| ie_o | output | 1 | Interrupt-enable flag |
| bank_o | output | 2 | Register-bank selection |
| halt_req_o | output | 1 | One-cycle halt request |
| stop_req_o | output | 1 | One-cycle stop request |
| done_o | output | 1 | Results of an issued operation are present |

## Verification
A taken branch and an operand write-back happen in the same cycle for both the test-and-clear and the decrement loop. The bench provokes this by sweeping all 256 operand values against all 8 bit indices, plus every counter value for the loop. In each result cycle it checks the branch target, the taken flag, the write-back enable and the modified byte together against arithmetic done in the bench. Program counters near 0 and 0xFFFF, and both signs of displacement, exercise wrap. Control operations are interleaved so that a flag or bank change cannot leak into neighbouring cycles.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_BR_ONE     = 4'd1,
        OP_BR_ZERO    = 4'd2,
        OP_BR_TSTCLR  = 4'd3,
        OP_DEC_LOOP   = 4'd4,
        OP_BANK_SEL   = 4'd5,
        OP_INT_ON     = 4'd6,
        OP_INT_OFF    = 4'd7,
        OP_REQ_HALT   = 4'd8,
        OP_REQ_STOP   = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        CTL_NONE = 2'd0,
        CTL_HALT = 2'd1,
        CTL_STOP = 2'd2
    } sleep_e;

    function automatic logic is_cond_branch(input op_e op);
        return (op == OP_BR_ONE) || (op == OP_BR_ZERO) ||
               (op == OP_BR_TSTCLR) || (op == OP_DEC_LOOP);
    endfunction

    function automatic op_e decode_op(input logic [3:0] raw);
        op_e o;
        case (raw)
            4'd1:    o = OP_BR_ONE;
            4'd2:    o = OP_BR_ZERO;
            4'd3:    o = OP_BR_TSTCLR;
            4'd4:    o = OP_DEC_LOOP;
            4'd5:    o = OP_BANK_SEL;
            4'd6:    o = OP_INT_ON;
            4'd7:    o = OP_INT_OFF;
            4'd8:    o = OP_REQ_HALT;
            4'd9:    o = OP_REQ_STOP;
            default: o = OP_NOP;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/bitbr_cond.sv
module bitbr_cond
    import bitbr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  op_e               op_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    output logic              take_o,
    output logic              wb_en_o,
    output logic [DATA_W-1:0] wb_data_o
);

    logic [DATA_W-1:0] onehot;
    logic [DATA_W-1:0] counter_dec;
    logic              sel_bit;

    // one-hot mask of the tested bit, built per lane
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign onehot[g] = (bit_idx_i == IDX_W'(g));
    end

    assign sel_bit     = |(opnd_i & onehot);
    assign counter_dec = opnd_i - DATA_W'(1);

    always_comb begin
        take_o    = 1'b0;
        wb_en_o   = 1'b0;
        wb_data_o = opnd_i;
        case (op_i)
            OP_BR_ONE:  take_o = sel_bit;
            OP_BR_ZERO: take_o = ~sel_bit;
            OP_BR_TSTCLR: begin
                take_o    = sel_bit;
                wb_en_o   = sel_bit;
                wb_data_o = opnd_i & ~onehot;
            end
            OP_DEC_LOOP: begin
                // a zero counter wraps to all ones and keeps looping
                take_o    = |counter_dec;
                wb_en_o   = 1'b1;
                wb_data_o = counter_dec;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bitbr_target.sv
module bitbr_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8,
    parameter int LEN_W  = 3
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic              take_i,
    output logic [PC_W-1:0]   next_pc_o
);

    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] jump_pc;

    // base of every branch is the address after this instruction
    assign seq_pc   = pc_i + PC_W'(len_i);
    assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    assign jump_pc  = seq_pc + disp_ext;
    assign next_pc_o = take_i ? jump_pc : seq_pc;

endmodule

// File: rtl/bitbr_ctrl.sv
module bitbr_ctrl
    import bitbr_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  op_e               op_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              ie_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              halt_req_o,
    output logic              stop_req_o
);

    sleep_e sleep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_o    <= 1'b0;
            bank_o  <= '0;
            sleep_q <= CTL_NONE;
        end else begin
            sleep_q <= CTL_NONE;
            if (valid_i) begin
                case (op_i)
                    OP_BANK_SEL: bank_o  <= bank_i;
                    OP_INT_ON:   ie_o    <= 1'b1;
                    OP_INT_OFF:  ie_o    <= 1'b0;
                    OP_REQ_HALT: sleep_q <= CTL_HALT;
                    OP_REQ_STOP: sleep_q <= CTL_STOP;
                    default: ;
                endcase
            end
        end
    end

    assign halt_req_o = (sleep_q == CTL_HALT);
    assign stop_req_o = (sleep_q == CTL_STOP);

endmodule

// File: rtl/bitbr_exec_unit.sv
module bitbr_exec_unit
    import bitbr_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int DISP_W = 8,
    parameter int LEN_W  = 3,
    parameter int BANK_W = 2,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [PC_W-1:0]   pc_next_o,
    output logic              taken_o,
    output logic              wb_en_o,
    output logic [DATA_W-1:0] wb_data_o,
    output logic              ie_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              halt_req_o,
    output logic              stop_req_o,
    output logic              done_o
);

    op_e               op_dec;
    logic              take_c;
    logic              wb_en_c;
    logic [DATA_W-1:0] wb_data_c;
    logic [PC_W-1:0]   next_pc_c;

    assign op_dec = decode_op(op_i);

    bitbr_cond #(.DATA_W(DATA_W)) i_cond (
        .op_i      (op_dec),
        .opnd_i    (opnd_i),
        .bit_idx_i (bit_idx_i),
        .take_o    (take_c),
        .wb_en_o   (wb_en_c),
        .wb_data_o (wb_data_c)
    );

    bitbr_target #(.PC_W(PC_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) i_target (
        .pc_i      (pc_i),
        .len_i     (len_i),
        .disp_i    (disp_i),
        .take_i    (take_c),
        .next_pc_o (next_pc_c)
    );

    bitbr_ctrl #(.BANK_W(BANK_W)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (valid_i),
        .op_i       (op_dec),
        .bank_i     (bank_i),
        .ie_o       (ie_o),
        .bank_o     (bank_o),
        .halt_req_o (halt_req_o),
        .stop_req_o (stop_req_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_next_o <= '0;
            taken_o   <= 1'b0;
            wb_en_o   <= 1'b0;
            wb_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o  <= valid_i;
            taken_o <= valid_i & take_c & is_cond_branch(op_dec);
            wb_en_o <= valid_i & wb_en_c;
            if (valid_i) begin
                pc_next_o <= next_pc_c;
                wb_data_o <= wb_data_c;
            end
        end
    end

endmodule

// File: rtl/bitbr_exec_chk.sv
module bitbr_exec_chk #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int DISP_W = 8,
    parameter int LEN_W  = 3,
    parameter int BANK_W = 2,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [3:0]        op_i,
    input logic [LEN_W-1:0]  len_i,
    input logic [PC_W-1:0]   pc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [IDX_W-1:0]  bit_idx_i,
    input logic [PC_W-1:0]   pc_next_o,
    input logic              taken_o,
    input logic              wb_en_o,
    input logic [DATA_W-1:0] wb_data_o,
    input logic              ie_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              halt_req_o,
    input logic              stop_req_o,
    input logic              done_o
);

    logic armed;
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst_q |-> (pc_next_o == '0 && !ie_o && bank_o == '0 && !taken_o &&
                   !wb_en_o && !halt_req_o && !stop_req_o && !done_o));

    // R2
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(valid_i) |-> (!done_o && !taken_o && !wb_en_o &&
                             !halt_req_o && !stop_req_o && $stable(pc_next_o)));

    // R3 / R4 fall-through arithmetic
    p_seq_pc_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        (done_o && !taken_o) |-> pc_next_o == $past(pc_i) + PC_W'($past(len_i)));

    // R5
    p_tstclr_bit_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(valid_i) && $past(op_i) == 4'd3 && wb_en_o) |->
            (taken_o && wb_data_o[$past(bit_idx_i)] == 1'b0));

    // R6
    p_dec_loop_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(valid_i) && $past(op_i) == 4'd4) |->
            (wb_en_o && wb_data_o == $past(opnd_i) - DATA_W'(1) &&
             taken_o == (wb_data_o != '0)));

    // R7
    p_bank_hold_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        !($past(valid_i) && $past(op_i) == 4'd5) |-> $stable(bank_o));

    // R8
    p_ie_hold_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        !($past(valid_i) && ($past(op_i) == 4'd6 || $past(op_i) == 4'd7))
            |-> $stable(ie_o));

    // R9
    p_sleep_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(halt_req_o && stop_req_o));

    // R9
    p_halt_pulse_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        halt_req_o |-> ($past(valid_i) && $past(op_i) == 4'd8));

    // R10
    p_no_branch_r10: assert property (@(posedge clk) disable iff (rst || !armed)
        taken_o |-> ($past(op_i) >= 4'd1 && $past(op_i) <= 4'd4));

endmodule

bind bitbr_exec_unit bitbr_exec_chk #(
    .PC_W(PC_W), .DATA_W(DATA_W), .DISP_W(DISP_W), .LEN_W(LEN_W), .BANK_W(BANK_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .op_i       (op_i),
    .len_i      (len_i),
    .pc_i       (pc_i),
    .opnd_i     (opnd_i),
    .bit_idx_i  (bit_idx_i),
    .pc_next_o  (pc_next_o),
    .taken_o    (taken_o),
    .wb_en_o    (wb_en_o),
    .wb_data_o  (wb_data_o),
    .ie_o       (ie_o),
    .bank_o     (bank_o),
    .halt_req_o (halt_req_o),
    .stop_req_o (stop_req_o),
    .done_o     (done_o)
);

// File: tb/test_bitbr_exec_unit.sv
module test_bitbr_exec_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [2:0]  len_i = '0;
    logic [7:0]  disp_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  opnd_i = '0;
    logic [2:0]  bit_idx_i = '0;
    logic [1:0]  bank_i = '0;
    logic [15:0] pc_next_o;
    logic        taken_o, wb_en_o, ie_o, halt_req_o, stop_req_o, done_o;
    logic [7:0]  wb_data_o;
    logic [1:0]  bank_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic        m_ie   = 1'b0;
    logic [1:0]  m_bank = 2'd0;
    logic [15:0] m_pc   = 16'd0;

    bitbr_exec_unit i_bitbr_exec_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .len_i(len_i),
        .disp_i(disp_i), .pc_i(pc_i), .opnd_i(opnd_i), .bit_idx_i(bit_idx_i),
        .bank_i(bank_i), .pc_next_o(pc_next_o), .taken_o(taken_o),
        .wb_en_o(wb_en_o), .wb_data_o(wb_data_o), .ie_o(ie_o), .bank_o(bank_o),
        .halt_req_o(halt_req_o), .stop_req_o(stop_req_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // issue one operation, then check the result cycle against the model
    task automatic issue(input string req, input logic [3:0] op, input logic [2:0] len,
                         input logic [7:0] disp, input logic [15:0] pc,
                         input logic [7:0] opnd, input logic [2:0] bidx,
                         input logic [1:0] bnk);
        logic        bitv, e_tk, e_wb, e_halt, e_stop;
        logic [7:0]  e_data;
        logic [15:0] seq, tgt;
        @(negedge clk);
        valid_i = 1'b1; op_i = op; len_i = len; disp_i = disp; pc_i = pc;
        opnd_i = opnd; bit_idx_i = bidx; bank_i = bnk;
        bitv = opnd[bidx];
        e_tk = 1'b0; e_wb = 1'b0; e_data = 8'h00; e_halt = 1'b0; e_stop = 1'b0;
        case (op)
            4'd1: e_tk = bitv;
            4'd2: e_tk = !bitv;
            4'd3: begin e_tk = bitv; e_wb = bitv;
                        e_data = opnd & ~(8'h01 << bidx); end
            4'd4: begin e_data = opnd - 8'd1; e_wb = 1'b1;
                        e_tk = (e_data != 8'd0); end
            4'd5: m_bank = bnk;
            4'd6: m_ie = 1'b1;
            4'd7: m_ie = 1'b0;
            4'd8: e_halt = 1'b1;
            4'd9: e_stop = 1'b1;
            default: ;
        endcase
        seq = pc + {13'd0, len};
        tgt = seq + {{8{disp[7]}}, disp};
        m_pc = e_tk ? tgt : seq;
        @(negedge clk);
        valid_i = 1'b0;
        chk(req, "done", {31'd0, done_o}, 32'd1);
        chk(req, "pc", {16'd0, pc_next_o}, {16'd0, m_pc});
        chk(req, "taken", {31'd0, taken_o}, {31'd0, e_tk});
        chk(req, "wb_en", {31'd0, wb_en_o}, {31'd0, e_wb});
        if (e_wb) chk(req, "wb_data", {24'd0, wb_data_o}, {24'd0, e_data});
        chk(req, "ie", {31'd0, ie_o}, {31'd0, m_ie});
        chk(req, "bank", {30'd0, bank_o}, {30'd0, m_bank});
        chk(req, "halt", {31'd0, halt_req_o}, {31'd0, e_halt});
        chk(req, "stop", {31'd0, stop_req_o}, {31'd0, e_stop});
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk(req, "idle done", {31'd0, done_o}, 32'd0);
        chk(req, "idle taken", {31'd0, taken_o}, 32'd0);
        chk(req, "idle wb_en", {31'd0, wb_en_o}, 32'd0);
        chk(req, "idle halt", {31'd0, halt_req_o}, 32'd0);
        chk(req, "idle stop", {31'd0, stop_req_o}, 32'd0);
        chk(req, "idle pc", {16'd0, pc_next_o}, {16'd0, m_pc});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] pcv;
        logic [7:0]  dv;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1", "pc", {16'd0, pc_next_o}, 32'd0);
        chk("R1", "ie", {31'd0, ie_o}, 32'd0);
        chk("R1", "bank", {30'd0, bank_o}, 32'd0);
        chk("R1", "done", {31'd0, done_o}, 32'd0);
        chk("R1", "wb_en", {31'd0, wb_en_o}, 32'd0);
        rst = 1'b0;
        idle_check("R2");

        // R3 R4 R5: every operand byte against every bit index
        for (int op = 1; op <= 3; op++) begin
            for (int v = 0; v < 256; v++) begin
                for (int b = 0; b < 8; b++) begin
                    pcv = 16'(v * 257 + b * 31 + op * 4099);
                    if (v == 0)   pcv = 16'hFFFE;
                    if (v == 255) pcv = 16'h0001;
                    dv  = 8'(v * 13 + b * 7 + op);
                    issue(op == 1 ? "R3" : (op == 2 ? "R4" : "R5"), 4'(op),
                          (b % 2 == 0) ? 3'd3 : 3'd4, dv, pcv, 8'(v), 3'(b), 2'(b));
                end
            end
        end
        idle_check("R2");

        // R6: every counter value, including 0 wrapping and 1 ending the loop
        for (int v = 0; v < 256; v++) begin
            issue("R6", 4'd4, (v % 2 == 0) ? 3'd2 : 3'd3, 8'(255 - v),
                  16'(v * 521 + 16'hFF00), 8'(v), 3'(v), 2'(v));
        end

        // R7: each bank value, with other ops in between
        for (int k = 0; k < 4; k++) begin
            issue("R7", 4'd5, 3'd2, 8'h00, 16'(k * 100), 8'h00, 3'd0, 2'(k));
            issue("R7", 4'd0, 3'd1, 8'h00, 16'(k * 100 + 2), 8'hFF, 3'd0, 2'(3 - k));
            issue("R7", 4'd3, 3'd4, 8'h80, 16'(k * 100 + 3), 8'hFF, 3'(k), 2'(k + 1));
        end

        // R8: enable, disable, and ops that must not touch the flag
        issue("R8", 4'd6, 3'd1, 8'h00, 16'h1000, 8'h00, 3'd0, 2'd1);
        issue("R8", 4'd4, 3'd2, 8'hF0, 16'h1001, 8'h01, 3'd0, 2'd2);
        issue("R8", 4'd7, 3'd1, 8'h00, 16'h1003, 8'h00, 3'd0, 2'd3);
        issue("R8", 4'd5, 3'd2, 8'h00, 16'h1004, 8'h00, 3'd0, 2'd2);
        issue("R8", 4'd6, 3'd1, 8'h00, 16'h1006, 8'h00, 3'd0, 2'd0);
        issue("R8", 4'd6, 3'd1, 8'h00, 16'h1007, 8'h00, 3'd0, 2'd0);

        // R9: request pulses, one cycle wide, back to back and isolated
        issue("R9", 4'd8, 3'd1, 8'h7F, 16'hFFFF, 8'h00, 3'd0, 2'd0);
        idle_check("R9");
        issue("R9", 4'd9, 3'd1, 8'h80, 16'h2000, 8'hFF, 3'd7, 2'd0);
        idle_check("R9");
        issue("R9", 4'd8, 3'd1, 8'h00, 16'h2001, 8'h00, 3'd0, 2'd0);
        issue("R9", 4'd9, 3'd1, 8'h00, 16'h2002, 8'h00, 3'd0, 2'd0);
        idle_check("R9");

        // R10: no-op and unused codes change nothing but the sequential PC
        for (int op = 10; op < 16; op++) begin
            for (int v = 0; v < 8; v++) begin
                issue("R10", 4'(op), 3'(v), 8'(v * 37), 16'(op * 4000 + v),
                      8'(v * 33), 3'(v), 2'(v));
            end
        end
        issue("R10", 4'd0, 3'd1, 8'hFF, 16'hFFFF, 8'h00, 3'd0, 2'd3);
        idle_check("R2");

        finish_run();
    end

endmodule